// File: doc/BRIEF.md
# Dual-Reload Programmable Timer Channel

This block is one 32-bit timer/counter channel. On every count tick it steps up or down. When it reaches its terminal value (zero going down, all-ones going up), it either stops or reloads and keeps running. The reload value comes from one of two period registers. In alternating mode the choice between them follows the channel's toggle flop, so two period registers produce a PWM waveform with independent high and low times.

A count tick comes from one of four clock-enable rates derived from the 50 MHz system clock, or from a selected edge of an external input or of a neighbouring channel's output. A hardware gate can suspend counting, and its polarity is selectable. A hardware trigger, with selectable source and edge, loads the channel and starts it. The trigger can be limited to a stopped channel or also allowed to restart a running one. The host controls the channel through single-cycle strobes: start, stop, load, reset, toggle set and toggle clear. It observes the live count, the running flag and the toggle state. The output pin carries either the terminal-count pulse or the toggle, passed directly, inverted, or forced to a constant level.

Top module: `dual_reload_timer`

## Requirements
- R1: On a count tick while running and gated open, the count rises by one when `cfg_count_up`=1 and falls by one when it is 0.
- R2: A tick that finds the count at its terminal value raises `tc_pulse` for the following cycle and inverts the toggle. The terminal value is 0 counting down and all-ones counting up.
- R3: At terminal count with `cfg_repeat`=0, the count holds the terminal value and `running` clears. With `cfg_repeat`=1, the count reloads and the channel keeps running.
- R4: Each reload, whether from a load strobe, a trigger or a terminal count, takes `reload_b` when `cfg_alt_reload`=1 and the toggle value after that cycle is 1. In every other case it takes `reload_a`.
- R5: With `cfg_toggle_out`=1 the output source is the toggle, otherwise `tc_pulse`. `cfg_out_mode` sets the pin: 00 source, 01 inverted source, 10 constant 0, 11 constant 1.
- R6: `cfg_clk_sel` selects the tick. 0000 ticks every cycle, 0001 / 0010 / 0011 use the prescaled enables, 0101 / 0110 / 0111 use the rising / falling / either edge of `ext_in`, and 1001 / 1010 / 1011 use the same edges of `nbr_in`. Any other code gives no tick.
- R7: The prescaled enables pulse for one cycle every 5, 50 and 500 cycles. Their phase is counted from reset release.
- R8: The gate level is 1 when `cfg_gate_src`=00, `ext_in` when 01, and `nbr_in` when 1x. Counting is suspended while the gate level equals `cfg_gate_pol`.
- R9: The trigger signal is none for `cfg_trig_src`=00, `ext_in` for 01 and `nbr_in` for 1x. `cfg_trig_edge` selects the edge: 00 none, 01 rising, 10 falling, 11 either. An accepted trigger reloads the count and sets `running`. With `cfg_retrig`=0, a trigger that arrives while running is ignored.
- R10: The strobes take effect on the next edge. `cmd_reset` clears count and `running`. `cmd_load` reloads the count. `cmd_stop` clears `running` and overrides `cmd_start`. A strobe held at 0 does nothing.
- R11: `cmd_tset` sets the toggle, `cmd_tclr` clears it, and both take precedence over a terminal-count inversion. `cmd_tset` wins over `cmd_tclr`.
- R12: During reset, count is 0, `running` is 0, the toggle is 0 and `tc_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_clk_sel | input | 4 | Tick source code |
| cfg_count_up | input | 1 | 1 counts up, 0 counts down |
| cfg_repeat | input | 1 | Reload at terminal count instead of stopping |
| cfg_alt_reload | input | 1 | Alternate reload between A and B by toggle |
| cfg_toggle_out | input | 1 | Output source: 1 toggle, 0 terminal pulse |
| cfg_out_mode | input | 2 | Direct, inverted, forced low, forced high |
| cfg_gate_src | input | 2 | Gate source: tied high, external, neighbour |
| cfg_gate_pol | input | 1 | Gate level that suspends counting |
| cfg_trig_src | input | 2 | Trigger source: none, external, neighbour |
| cfg_trig_edge | input | 2 | Trigger edge: none, rising, falling, either |
| cfg_retrig | input | 1 | Accept triggers while running |
| reload_a | input | 32 | Period register A |
| reload_b | input | 32 | Period register B |
| cmd_start | input | 1 | Start strobe |
| cmd_stop | input | 1 | Stop strobe |
| cmd_load | input | 1 | Load strobe |
| cmd_reset | input | 1 | Counter reset strobe |
| cmd_tset | input | 1 | Toggle set strobe |
| cmd_tclr | input | 1 | Toggle clear strobe |
| ext_in | input | 1 | External clock/gate/trigger input, synchronous |
| nbr_in | input | 1 | Neighbour channel output, synchronous |
| count | output | 32 | Live count |
| running | output | 1 | Channel running |
| toggle | output | 1 | Toggle flop state |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| tmr_out | output | 1 | Conditioned output pin |

## Verification
The assertions check the strobe effects on every cycle: reset clearing, toggle set and clear precedence, and a held count while the channel is idle. They also check that every terminal pulse coincides with a toggle inversion, and that a non-repeating channel has stopped once its pulse appears. Tick selection, prescaler phase, gate and trigger muxing, and the choice between A and B depend on several inputs over many cycles. Only the bench can show these, through its cycle-level reference model, a directed PWM duty measurement, a reserved-code freeze, an ignored retrigger and an up-count that stops at all-ones.

// File: rtl/tmr_pkg.sv
// Shared encodings for the timer channel.
// Assumes: the codes are fixed by the channel's configuration interface.
package tmr_pkg;

    typedef enum logic [1:0] {
        OUT_DIRECT = 2'b00,
        OUT_INVERT = 2'b01,
        OUT_LOW    = 2'b10,
        OUT_HIGH   = 2'b11
    } out_mode_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_kind_e;

    // Returns whether the requested edge kind occurred.
    function automatic logic edge_hit(input edge_kind_e kind, input logic rise, input logic fall);
        case (kind)
            EDGE_RISE: return rise;
            EDGE_FALL: return fall;
            EDGE_ANY:  return rise | fall;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
// Cascaded clock-enable generator: stage i pulses once every
// DIV_0*..*DIV_i cycles, phase counted from reset release.
// Assumes: every divisor is at least 2.
module tmr_prescale #(
    parameter int unsigned DIV_0 = 5,
    parameter int unsigned DIV_1 = 10,
    parameter int unsigned DIV_2 = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [2:0] en_out
);
    localparam int unsigned NSTAGE = 3;
    localparam int unsigned DMAX   = (DIV_0 > DIV_1) ? ((DIV_0 > DIV_2) ? DIV_0 : DIV_2)
                                                     : ((DIV_1 > DIV_2) ? DIV_1 : DIV_2);
    localparam int unsigned CW     = $clog2(DMAX) + 1;

    logic [NSTAGE-1:0] en_in;
    assign en_in = {en_out[NSTAGE-2:0], 1'b1};

    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        localparam int unsigned D = (i == 0) ? DIV_0 : ((i == 1) ? DIV_1 : DIV_2);
        logic [CW-1:0] cnt;

        // Advance this stage whenever the previous stage wraps.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt <= '0;
            else if (en_in[i])
                cnt <= (cnt == CW'(D - 1)) ? '0 : cnt + 1'b1;
        end

        assign en_out[i] = en_in[i] && (cnt == CW'(D - 1));
    end
endmodule

// File: rtl/tmr_event.sv
// Input conditioning: edge detection on the external and neighbour
// inputs, tick source selection, gate level and trigger event.
// Assumes: ext_in and nbr_in are already synchronous to clk.
module tmr_event
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_in,
    input  logic       nbr_in,
    input  logic [2:0] en_pre,
    input  logic [3:0] clk_sel,
    input  logic [1:0] gate_src,
    input  logic [1:0] trig_src,
    input  logic [1:0] trig_edge,
    output logic       tick,
    output logic       gate_lvl,
    output logic       trig_evt
);
    localparam int unsigned NSRC = 2;   // index 0: external, 1: neighbour

    logic [NSRC-1:0] lvl, prev, rise, fall;
    assign lvl = {nbr_in, ext_in};

    for (genvar s = 0; s < NSRC; s++) begin : g_edge
        // Remember last cycle's level for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prev[s] <= 1'b0;
            else
                prev[s] <= lvl[s];
        end
        assign rise[s] = lvl[s] & ~prev[s];
        assign fall[s] = ~lvl[s] & prev[s];
    end

    // Select the count tick from the clock source code.
    always_comb begin
        tick = 1'b0;
        case (clk_sel)
            4'b0000: tick = 1'b1;
            4'b0001: tick = en_pre[0];
            4'b0010: tick = en_pre[1];
            4'b0011: tick = en_pre[2];
            4'b0101, 4'b0110, 4'b0111:
                tick = edge_hit(edge_kind_e'(clk_sel[1:0]), rise[0], fall[0]);
            4'b1001, 4'b1010, 4'b1011:
                tick = edge_hit(edge_kind_e'(clk_sel[1:0]), rise[1], fall[1]);
            default: tick = 1'b0;
        endcase
    end

    // Pick the gate level.
    always_comb begin
        case (gate_src)
            2'b00:   gate_lvl = 1'b1;
            2'b01:   gate_lvl = ext_in;
            default: gate_lvl = nbr_in;
        endcase
    end

    // Pick the trigger source and test the requested edge.
    always_comb begin
        case (trig_src)
            2'b00:   trig_evt = 1'b0;
            2'b01:   trig_evt = edge_hit(edge_kind_e'(trig_edge), rise[0], fall[0]);
            default: trig_evt = edge_hit(edge_kind_e'(trig_edge), rise[1], fall[1]);
        endcase
    end
endmodule

// File: rtl/tmr_core.sv
// Counter state: count, running flag, toggle flop, terminal pulse.
// Priority on the count: reset, load, trigger, tick step.
// Assumes: strobes are single-cycle and synchronous.
module tmr_core #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_up,
    input  logic         cfg_repeat,
    input  logic         cfg_alt,
    input  logic         cfg_retrig,
    input  logic [W-1:0] reload_a,
    input  logic [W-1:0] reload_b,
    input  logic         cmd_start,
    input  logic         cmd_stop,
    input  logic         cmd_load,
    input  logic         cmd_reset,
    input  logic         cmd_tset,
    input  logic         cmd_tclr,
    input  logic         tick,
    input  logic         gate_open,
    input  logic         trig_evt,
    output logic [W-1:0] count,
    output logic         running,
    output logic         toggle,
    output logic         tc_pulse
);
    localparam logic [W-1:0] TERM_UP = {W{1'b1}};

    logic         trig_ok, step, at_term, tc;
    logic         tog_n, run_n;
    logic [W-1:0] src, cnt_n;

    // Decide this cycle's step, terminal event and next state.
    always_comb begin
        trig_ok = trig_evt && (cfg_retrig || !running);
        at_term = cfg_up ? (count == TERM_UP) : (count == '0);
        step    = running && gate_open && tick && !cmd_reset && !cmd_load && !trig_ok;
        tc      = step && at_term;

        if (cmd_tset)      tog_n = 1'b1;
        else if (cmd_tclr) tog_n = 1'b0;
        else if (tc)       tog_n = ~toggle;
        else               tog_n = toggle;

        src = (cfg_alt && tog_n) ? reload_b : reload_a;

        if (cmd_reset)            cnt_n = '0;
        else if (cmd_load)        cnt_n = src;
        else if (trig_ok)         cnt_n = src;
        else if (tc)              cnt_n = cfg_repeat ? src : count;
        else if (step)            cnt_n = cfg_up ? count + 1'b1 : count - 1'b1;
        else                      cnt_n = count;

        if (cmd_reset || cmd_stop)       run_n = 1'b0;
        else if (cmd_start || trig_ok)   run_n = 1'b1;
        else if (tc && !cfg_repeat)      run_n = 1'b0;
        else                             run_n = running;
    end

    // Register the channel state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            running  <= 1'b0;
            toggle   <= 1'b0;
            tc_pulse <= 1'b0;
        end else begin
            count    <= cnt_n;
            running  <= run_n;
            toggle   <= tog_n;
            tc_pulse <= tc;
        end
    end
endmodule

// File: rtl/dual_reload_timer.sv
// Top of one timer channel: prescaler, input conditioning, counter
// core and output conditioning.
// Assumes: a 50 MHz clk; ext_in and nbr_in synchronous to clk.
module dual_reload_timer
    import tmr_pkg::*;
#(
    parameter int unsigned W      = 32,
    parameter int unsigned DIV_0  = 5,
    parameter int unsigned DIV_1  = 10,
    parameter int unsigned DIV_2  = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   cfg_clk_sel,
    input  logic         cfg_count_up,
    input  logic         cfg_repeat,
    input  logic         cfg_alt_reload,
    input  logic         cfg_toggle_out,
    input  logic [1:0]   cfg_out_mode,
    input  logic [1:0]   cfg_gate_src,
    input  logic         cfg_gate_pol,
    input  logic [1:0]   cfg_trig_src,
    input  logic [1:0]   cfg_trig_edge,
    input  logic         cfg_retrig,
    input  logic [W-1:0] reload_a,
    input  logic [W-1:0] reload_b,
    input  logic         cmd_start,
    input  logic         cmd_stop,
    input  logic         cmd_load,
    input  logic         cmd_reset,
    input  logic         cmd_tset,
    input  logic         cmd_tclr,
    input  logic         ext_in,
    input  logic         nbr_in,
    output logic [W-1:0] count,
    output logic         running,
    output logic         toggle,
    output logic         tc_pulse,
    output logic         tmr_out
);
    logic [2:0] en_pre;
    logic       tick, gate_lvl, trig_evt, gate_open, out_src;

    tmr_prescale #(.DIV_0(DIV_0), .DIV_1(DIV_1), .DIV_2(DIV_2)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_out (en_pre)
    );

    tmr_event u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_in    (ext_in),
        .nbr_in    (nbr_in),
        .en_pre    (en_pre),
        .clk_sel   (cfg_clk_sel),
        .gate_src  (cfg_gate_src),
        .trig_src  (cfg_trig_src),
        .trig_edge (cfg_trig_edge),
        .tick      (tick),
        .gate_lvl  (gate_lvl),
        .trig_evt  (trig_evt)
    );

    assign gate_open = (gate_lvl != cfg_gate_pol);

    tmr_core #(.W(W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_up     (cfg_count_up),
        .cfg_repeat (cfg_repeat),
        .cfg_alt    (cfg_alt_reload),
        .cfg_retrig (cfg_retrig),
        .reload_a   (reload_a),
        .reload_b   (reload_b),
        .cmd_start  (cmd_start),
        .cmd_stop   (cmd_stop),
        .cmd_load   (cmd_load),
        .cmd_reset  (cmd_reset),
        .cmd_tset   (cmd_tset),
        .cmd_tclr   (cmd_tclr),
        .tick       (tick),
        .gate_open  (gate_open),
        .trig_evt   (trig_evt),
        .count      (count),
        .running    (running),
        .toggle     (toggle),
        .tc_pulse   (tc_pulse)
    );

    // Condition the output pin from the selected source and mode.
    always_comb begin
        out_src = cfg_toggle_out ? toggle : tc_pulse;
        case (out_mode_e'(cfg_out_mode))
            OUT_DIRECT: tmr_out = out_src;
            OUT_INVERT: tmr_out = ~out_src;
            OUT_LOW:    tmr_out = 1'b0;
            default:    tmr_out = 1'b1;
        endcase
    end
endmodule

// File: rtl/tmr_chk.sv
// Protocol checker for the timer channel, bound to the top module.
// Assumes: only top-level ports are observed.
module tmr_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_repeat,
    input logic [1:0]   cfg_trig_edge,
    input logic         cmd_start,
    input logic         cmd_load,
    input logic         cmd_reset,
    input logic         cmd_tset,
    input logic         cmd_tclr,
    input logic [W-1:0] count,
    input logic         running,
    input logic         toggle,
    input logic         tc_pulse
);
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (count == '0 && !running));  // R10

    AST_TSET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_tset |=> toggle);  // R11

    AST_TCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_tclr && !cmd_tset) |=> !toggle);  // R11

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cmd_load && !cmd_reset && cfg_trig_edge == 2'b00) |=> $stable(count));  // R10

    AST_TC_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && !$past(cmd_tset) && !$past(cmd_tclr)) |-> (toggle != $past(toggle)));  // R2

    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && !$past(cfg_repeat) && !$past(cmd_start) && $past(cfg_trig_edge) == 2'b00)
            |-> !running);  // R3
endmodule

bind dual_reload_timer tmr_chk #(.W(W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_repeat    (cfg_repeat),
    .cfg_trig_edge (cfg_trig_edge),
    .cmd_start     (cmd_start),
    .cmd_load      (cmd_load),
    .cmd_reset     (cmd_reset),
    .cmd_tset      (cmd_tset),
    .cmd_tclr      (cmd_tclr),
    .count         (count),
    .running       (running),
    .toggle        (toggle),
    .tc_pulse      (tc_pulse)
);

// File: tb/dual_reload_timer_test.sv
// Bench: cycle-level reference model built from the requirements,
// directed corner cases, then seeded random stimulus.
module dual_reload_timer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  cfg_clk_sel;
    logic        cfg_count_up, cfg_repeat, cfg_alt_reload, cfg_toggle_out;
    logic [1:0]  cfg_out_mode, cfg_gate_src, cfg_trig_src, cfg_trig_edge;
    logic        cfg_gate_pol, cfg_retrig;
    logic [31:0] reload_a, reload_b;
    logic        cmd_start, cmd_stop, cmd_load, cmd_reset, cmd_tset, cmd_tclr;
    logic        ext_in, nbr_in;
    logic [31:0] count;
    logic        running, toggle, tc_pulse, tmr_out;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dual_reload_timer uut (.*);

    // Reference model state
    logic [31:0] m_cnt;
    logic        m_run, m_tog, m_tc, m_pext, m_pnbr;
    int          m_p0, m_p1, m_p2;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic edge_of(input logic [1:0] k, input logic r, input logic f);
        case (k)
            2'b01: return r;
            2'b10: return f;
            2'b11: return r | f;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic m_out();
        logic s;
        s = cfg_toggle_out ? m_tog : m_tc;
        case (cfg_out_mode)
            2'b00: return s;
            2'b01: return ~s;
            2'b10: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic m_reset();
        m_cnt = '0; m_run = 0; m_tog = 0; m_tc = 0; m_pext = 0; m_pnbr = 0;
        m_p0 = 0; m_p1 = 0; m_p2 = 0;
    endtask

    // One clock edge of the model, from the inputs now applied.
    task automatic m_step();
        logic e0, e1, e2, er, ef, nr, nf, tick, glvl, gopen, tev, tok, step, tc, tn;
        logic [31:0] src, term;
        e0 = (m_p0 == 4); e1 = e0 && (m_p1 == 9); e2 = e1 && (m_p2 == 9);   // R7
        er = ext_in & ~m_pext; ef = ~ext_in & m_pext;
        nr = nbr_in & ~m_pnbr; nf = ~nbr_in & m_pnbr;
        case (cfg_clk_sel)                                                  // R6
            4'b0000: tick = 1;
            4'b0001: tick = e0;
            4'b0010: tick = e1;
            4'b0011: tick = e2;
            4'b0101, 4'b0110, 4'b0111: tick = edge_of(cfg_clk_sel[1:0], er, ef);
            4'b1001, 4'b1010, 4'b1011: tick = edge_of(cfg_clk_sel[1:0], nr, nf);
            default: tick = 0;
        endcase
        glvl = (cfg_gate_src == 2'b00) ? 1'b1 : (cfg_gate_src == 2'b01) ? ext_in : nbr_in;  // R8
        gopen = (glvl != cfg_gate_pol);
        tev = (cfg_trig_src == 2'b00) ? 1'b0 :                              // R9
              (cfg_trig_src == 2'b01) ? edge_of(cfg_trig_edge, er, ef) : edge_of(cfg_trig_edge, nr, nf);
        tok = tev && (cfg_retrig || !m_run);
        term = cfg_count_up ? 32'hFFFF_FFFF : 32'h0;
        step = m_run && gopen && tick && !cmd_reset && !cmd_load && !tok;
        tc = step && (m_cnt == term);                                       // R2
        tn = cmd_tset ? 1'b1 : cmd_tclr ? 1'b0 : tc ? ~m_tog : m_tog;       // R11
        src = (cfg_alt_reload && tn) ? reload_b : reload_a;                 // R4
        if (cmd_reset) m_cnt = '0;                                          // R10
        else if (cmd_load || tok) m_cnt = src;
        else if (tc) m_cnt = cfg_repeat ? src : m_cnt;                      // R3
        else if (step) m_cnt = cfg_count_up ? m_cnt + 1 : m_cnt - 1;        // R1
        if (cmd_reset || cmd_stop) m_run = 0;
        else if (cmd_start || tok) m_run = 1;
        else if (tc && !cfg_repeat) m_run = 0;
        m_tog = tn; m_tc = tc;
        m_pext = ext_in; m_pnbr = nbr_in;
        if (e0) begin
            m_p0 = 0;
            m_p1 = (m_p1 == 9) ? 0 : m_p1 + 1;
            if (e1) m_p2 = (m_p2 == 9) ? 0 : m_p2 + 1;
        end else m_p0 = m_p0 + 1;
    endtask

    task automatic compare();
        chk(count == m_cnt, "R1 R3 R4 R6 count", count, m_cnt);
        chk(running == m_run, "R3 R9 R10 running", running, m_run);
        chk(toggle == m_tog, "R2 R11 toggle", toggle, m_tog);
        chk(tc_pulse == m_tc, "R2 tc_pulse", tc_pulse, m_tc);
        chk(tmr_out == m_out(), "R5 tmr_out", tmr_out, m_out());
    endtask

    // Apply current inputs for one edge, compare, drop strobes.
    task automatic step1();
        m_step();
        @(negedge clk);
        compare();
        cmd_start = 0; cmd_stop = 0; cmd_load = 0; cmd_reset = 0; cmd_tset = 0; cmd_tclr = 0;
    endtask

    task automatic base_cfg();
        cfg_clk_sel = 4'b0000; cfg_count_up = 0; cfg_repeat = 1; cfg_alt_reload = 0;
        cfg_toggle_out = 0; cfg_out_mode = 2'b00; cfg_gate_src = 2'b00; cfg_gate_pol = 0;
        cfg_trig_src = 2'b00; cfg_trig_edge = 2'b00; cfg_retrig = 0;
    endtask

    initial begin
        #(1_500_000);
        if (!finished) begin
            n_fail++;
            $display("FAIL R12 watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int highs;
        logic [31:0] snap;
        rst_n = 0; base_cfg();
        reload_a = 0; reload_b = 0; ext_in = 0; nbr_in = 0;
        cmd_start = 0; cmd_stop = 0; cmd_load = 0; cmd_reset = 0; cmd_tset = 0; cmd_tclr = 0;
        m_reset();
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(count == 0, "R12 count", count, 0);
        chk(running == 0, "R12 running", running, 0);
        chk(toggle == 0, "R12 toggle", toggle, 0);
        chk(tc_pulse == 0, "R12 tc_pulse", tc_pulse, 0);
        rst_n = 1;

        // R4 R5 PWM from two periods: high B+1, low A+1 cycles
        cfg_alt_reload = 1; cfg_toggle_out = 1; reload_a = 3; reload_b = 1;
        cmd_tclr = 1; cmd_load = 1; cmd_start = 1; step1();
        repeat (6) step1();
        highs = 0;
        for (int i = 0; i < 60; i++) begin
            step1();
            if (tmr_out) highs++;
        end
        chk(highs == 20, "R4 PWM high cycles", highs, 20);

        // R6 reserved clock code gives no tick
        cfg_clk_sel = 4'b0100; cmd_load = 1; cmd_start = 1; step1();
        snap = count;
        repeat (30) step1();
        chk(count == snap, "R6 reserved code froze count", count, snap);

        // R9 trigger without retrigger is ignored while running
        base_cfg(); cfg_repeat = 0; reload_a = 1000; cfg_trig_src = 2'b01; cfg_trig_edge = 2'b01;
        cmd_reset = 1; step1();
        ext_in = 1; step1();
        chk(count == 1000 && running, "R9 trigger loads and starts", count, 1000);
        repeat (10) step1();
        ext_in = 0; step1();
        ext_in = 1; step1();
        step1();
        chk(count < 995, "R9 retrigger ignored", count, 987);

        // R2 R3 up-count one-shot stops at all-ones
        base_cfg(); cfg_repeat = 0; cfg_count_up = 1; reload_a = 32'hFFFF_FFFC;
        cmd_load = 1; cmd_start = 1; step1();
        repeat (10) step1();
        chk(count == 32'hFFFF_FFFF, "R3 stop at all-ones", count, 32'hFFFF_FFFF);
        chk(running == 0, "R3 stopped after terminal", running, 0);

        // Seeded random stimulus against the model
        void'($urandom(32'd20240607));
        for (int c = 0; c < 20000; c++) begin
            if (c % 256 == 0) begin
                cfg_clk_sel = 4'($urandom);
                if ($urandom % 2) cfg_clk_sel = 4'($urandom % 3);
                cfg_count_up = 1'($urandom); cfg_repeat = 1'($urandom);
                cfg_alt_reload = 1'($urandom); cfg_toggle_out = 1'($urandom);
                cfg_out_mode = 2'($urandom); cfg_gate_src = 2'($urandom);
                cfg_gate_pol = 1'($urandom); cfg_trig_src = 2'($urandom);
                cfg_trig_edge = 2'($urandom); cfg_retrig = 1'($urandom);
                reload_a = cfg_count_up ? 32'hFFFF_FFFF - ($urandom % 24) : $urandom % 24;
                reload_b = cfg_count_up ? 32'hFFFF_FFFF - ($urandom % 24) : $urandom % 24;
            end
            if ($urandom % 4 == 0) ext_in = ~ext_in;
            if ($urandom % 5 == 0) nbr_in = ~nbr_in;
            cmd_start = ($urandom % 24 == 0); cmd_stop  = ($urandom % 40 == 0);
            cmd_load  = ($urandom % 32 == 0); cmd_reset = ($urandom % 64 == 0);
            cmd_tset  = ($urandom % 48 == 0); cmd_tclr  = ($urandom % 48 == 0);
            step1();
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule